// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block decides, cycle by cycle, which of the oldest entries of a multi-threaded reorder buffer leave the machine. It looks at a small window of the oldest `WIDTH` entries of each thread. It picks one thread by rotating priority and retires the longest run of completed entries from the front of that thread's window. The storage holding the entries lives outside; it removes the entries flagged by `retireMask` on the next clock edge.

Instructions that must not run speculatively wait until they are the oldest entry of their thread. The controller then announces their sequence number to the issue logic, one such announcement per cycle. Each thread also runs its own state machine. The states cover normal running, idle, a squash that drains over several cycles, and a trap that waits for its latency and for outstanding store writebacks. A second trap flavour first waits for the thread's buffer to empty. The controller also tells the front end how many entries are free, and flags the cycles when that number has just changed.

Top module: `retire_ctl`

## Requirements
- R1: In a cycle, the selected thread retires the slots 0..k-1 of its window, where slot k is the first slot that is not both valid and completed. At most `WIDTH` slots retire. `retireMask` bit s stands for slot s and is always a contiguous run starting at bit 0.
- R2: A thread can retire only if its slot 0 is valid and completed. Among such threads the search starts at a rotating pointer, which is 0 after reset. After a retire, the pointer moves to the thread after the one that retired. `retireTid` names the thread.
- R3: A non-speculative entry is announced only when it sits valid and not completed in slot 0 of a Running or fetch-trap-waiting thread. The announcement comes one cycle after it becomes visible: `relValid` is set, with `relSeq` and `relTid`. Each such entry is announced once.
- R4: At most one announcement is made per cycle. When several threads request at once, the lowest thread index goes first and the others follow in later cycles.
- R5: A `squashReq` in Running or fetch-trap-waiting moves the thread to Squashing (state code 2) at the next edge. While Squashing, the thread neither retires nor announces. It stays there until `squashDone`, then goes to Running (0), or to Idle (1) if it is disabled.
- R6: A `trapReq` in Running moves the thread to TrapPending (3). Exactly `TRAP_LAT` cycles after the request edge, `trapSquash` pulses for one cycle and the thread enters Squashing. Nothing retires in TrapPending.
- R7: While `storeBusy` is high, a TrapPending thread whose latency has run out waits. It fires at the first edge after `storeBusy` falls.
- R8: A `fetchTrapReq` in Running moves the thread to FetchTrapPending (4). There it keeps retiring, and it moves to TrapPending at the first edge where its `robCount` is zero.
- R9: `freeEntries` for a thread equals `ROB_DEPTH` minus its `robCount`, registered. `freeUpdate` for that thread pulses for one cycle only after an edge at which `robCount` differed from its value at the previous edge.
- R10: A disabled Running thread goes to Idle, and Idle ignores trap and squash requests. An enabled Idle thread goes to Running. `stageActive` is low exactly when every thread is Idle.
- R11: After reset, every thread is Running with no trap counting. `stageActive` is 1, no announcement or trap pulse is present, `freeEntries` equals `ROB_DEPTH` and `freeUpdate` is 0.
- R12: In Running, a trap request takes priority over a squash request, and a squash request over a fetch-trap request. Squash requests are ignored in TrapPending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threadEnable | input | THREADS | Thread is allowed to run |
| headValid | input | THREADS*WIDTH | Window slot holds an entry (thread t, slot s at bit t*WIDTH+s) |
| headDone | input | THREADS*WIDTH | Window slot has completed execution |
| headNonSpec | input | THREADS*WIDTH | Window slot must not run speculatively |
| headSeq | input | THREADS*WIDTH*SEQ_W | Sequence number of each slot |
| robCount | input | THREADS*CNT_W | Occupied entries of each thread |
| squashReq | input | THREADS | Mispredict squash request |
| squashDone | input | THREADS | Buffer has finished removing squashed entries |
| trapReq | input | THREADS | Trap or fault raised at retire |
| fetchTrapReq | input | THREADS | Trap raised by the front end; waits for an empty buffer |
| storeBusy | input | THREADS | Older stores not yet written back |
| retireMask | output | WIDTH | Slots of the selected thread leaving this cycle |
| retireTid | output | TID_W | Thread selected for retirement |
| relValid | output | 1 | Non-speculative release announcement |
| relTid | output | TID_W | Thread of the announced entry |
| relSeq | output | SEQ_W | Sequence number of the announced entry |
| trapSquash | output | THREADS | One-cycle pulse: squash all entries of the thread |
| freeEntries | output | THREADS*CNT_W | Free entry count per thread |
| freeUpdate | output | THREADS | Free count has just changed |
| threadState | output | THREADS*3 | Per-thread state code |
| stageActive | output | 1 | Some thread is not Idle |

## Verification
The hardest case to reach is a trap whose latency has already run out while stores are still outstanding. The stimulus raises `storeBusy` before the trap request and holds it well past `TRAP_LAT` cycles, then drops it. The check is that the squash pulse comes exactly one edge later and not before. A second hard case is two threads asking for a non-speculative announcement in the same cycle. Both window heads are loaded at once, and the bench checks that the announcements come out in two consecutive cycles and are never repeated.

// File: rtl/retire_pkg.sv
package retire_pkg;

  typedef enum logic [2:0] {
    TS_RUN    = 3'd0,
    TS_IDLE   = 3'd1,
    TS_SQUASH = 3'd2,
    TS_TRAP   = 3'd3,
    TS_FTRAP  = 3'd4
  } thrState_e;

  // strobes from the per-thread control to the datapath
  typedef struct packed {
    logic retireOk;
    logic releaseOk;
    logic clrRelease;
  } thrStrobe_t;

endpackage

// File: rtl/retire_fsm.sv
module retire_fsm
  import retire_pkg::*;
#(
  parameter int THREADS  = 2,
  parameter int TRAP_LAT = 4,
  parameter int CNT_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [THREADS-1:0]       threadEnable,
  input  logic [THREADS-1:0]       squashReq,
  input  logic [THREADS-1:0]       squashDone,
  input  logic [THREADS-1:0]       trapReq,
  input  logic [THREADS-1:0]       fetchTrapReq,
  input  logic [THREADS-1:0]       storeBusy,
  input  logic [THREADS*CNT_W-1:0] robCount,
  output thrStrobe_t [THREADS-1:0] strobes,
  output logic [THREADS-1:0]       trapSquash,
  output logic [THREADS*3-1:0]     threadState,
  output logic                     stageActive
);

  localparam int LAT_W = $clog2(TRAP_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(TRAP_LAT - 1);

  logic [THREADS-1:0] notIdle;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    thrState_e        st, stNext;
    logic [LAT_W-1:0] lat, latNext;
    logic             fire, fireQ, robEmpty;
    thrStrobe_t       strb;

    assign robEmpty = (robCount[t*CNT_W +: CNT_W] == '0);

    always_comb begin
      stNext  = st;
      latNext = lat;
      fire    = 1'b0;
      unique case (st)
        TS_RUN: begin
          if (trapReq[t]) begin
            stNext  = TS_TRAP;
            latNext = '0;
          end else if (squashReq[t]) begin
            stNext = TS_SQUASH;
          end else if (fetchTrapReq[t]) begin
            stNext = TS_FTRAP;
          end else if (!threadEnable[t]) begin
            stNext = TS_IDLE;
          end
        end
        TS_IDLE: begin
          if (threadEnable[t]) stNext = TS_RUN;
        end
        TS_FTRAP: begin
          if (squashReq[t] && !trapReq[t]) begin
            stNext = TS_SQUASH;
          end else if (trapReq[t] || robEmpty) begin
            stNext  = TS_TRAP;
            latNext = '0;
          end
        end
        TS_TRAP: begin
          if (lat == LAT_LAST) begin
            if (!storeBusy[t]) begin
              stNext = TS_SQUASH;
              fire   = 1'b1;
            end
          end else begin
            latNext = lat + 1'b1;
          end
        end
        TS_SQUASH: begin
          if (squashDone[t]) stNext = threadEnable[t] ? TS_RUN : TS_IDLE;
        end
        default: stNext = TS_RUN;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st    <= TS_RUN;
        lat   <= '0;
        fireQ <= 1'b0;
      end else begin
        st    <= stNext;
        lat   <= latNext;
        fireQ <= fire;
      end
    end

    assign strb.retireOk   = (st == TS_RUN) || (st == TS_FTRAP);
    assign strb.releaseOk  = (st == TS_RUN) || (st == TS_FTRAP);
    assign strb.clrRelease = (st == TS_SQUASH);
    assign strobes[t]      = strb;
    assign trapSquash[t]   = fireQ;
    assign threadState[t*3 +: 3] = st;
    assign notIdle[t]      = (st != TS_IDLE);
  end

  assign stageActive = |notIdle;

endmodule

// File: rtl/retire_path.sv
module retire_path
  import retire_pkg::*;
#(
  parameter int THREADS   = 2,
  parameter int WIDTH     = 4,
  parameter int SEQ_W     = 16,
  parameter int ROB_DEPTH = 32,
  parameter int CNT_W     = 6,
  parameter int TID_W     = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  thrStrobe_t [THREADS-1:0]       strobes,
  input  logic [THREADS*WIDTH-1:0]       headValid,
  input  logic [THREADS*WIDTH-1:0]       headDone,
  input  logic [THREADS*WIDTH-1:0]       headNonSpec,
  input  logic [THREADS*WIDTH*SEQ_W-1:0] headSeq,
  input  logic [THREADS*CNT_W-1:0]       robCount,
  output logic [WIDTH-1:0]               retireMask,
  output logic [TID_W-1:0]               retireTid,
  output logic                           relValid,
  output logic [TID_W-1:0]               relTid,
  output logic [SEQ_W-1:0]               relSeq,
  output logic [THREADS*CNT_W-1:0]       freeEntries,
  output logic [THREADS-1:0]             freeUpdate
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(ROB_DEPTH);
  localparam logic [TID_W-1:0] LAST_T  = TID_W'(THREADS - 1);

  logic [THREADS-1:0] elig, relReq, relGrant;
  logic [TID_W-1:0]   rrPtr, pick, relPick;
  logic               pickFound, relAny;

  // retire selection with rotating priority
  for (genvar t = 0; t < THREADS; t++) begin : g_elig
    assign elig[t] = strobes[t].retireOk & headValid[t*WIDTH] & headDone[t*WIDTH];
  end

  always_comb begin
    int idx;
    pickFound = 1'b0;
    pick      = '0;
    for (int k = 0; k < THREADS; k++) begin
      idx = int'(rrPtr) + k;
      if (idx >= THREADS) idx = idx - THREADS;
      if (!pickFound && elig[idx]) begin
        pickFound = 1'b1;
        pick      = TID_W'(idx);
      end
    end
  end

  always_comb begin
    logic run;
    run = pickFound;
    for (int s = 0; s < WIDTH; s++) begin
      run = run & headValid[int'(pick)*WIDTH + s] & headDone[int'(pick)*WIDTH + s];
      retireMask[s] = run;
    end
  end

  assign retireTid = pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (pickFound) begin
      rrPtr <= (pick == LAST_T) ? '0 : pick + 1'b1;
    end
  end

  // non-speculative release, one per cycle, lowest thread first
  for (genvar t = 0; t < THREADS; t++) begin : g_rel
    logic             held;
    logic [SEQ_W-1:0] heldSeq;
    logic [SEQ_W-1:0] seq0;

    assign seq0 = headSeq[t*WIDTH*SEQ_W +: SEQ_W];
    assign relReq[t] = strobes[t].releaseOk & headValid[t*WIDTH] &
                       headNonSpec[t*WIDTH] & ~headDone[t*WIDTH] &
                       ~(held && heldSeq == seq0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held    <= 1'b0;
        heldSeq <= '0;
      end else if (strobes[t].clrRelease) begin
        held <= 1'b0;
      end else if (relGrant[t]) begin
        held    <= 1'b1;
        heldSeq <= seq0;
      end
    end
  end

  always_comb begin
    relAny   = 1'b0;
    relPick  = '0;
    relGrant = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (!relAny && relReq[t]) begin
        relAny      = 1'b1;
        relPick     = TID_W'(t);
        relGrant[t] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      relValid <= 1'b0;
      relTid   <= '0;
      relSeq   <= '0;
    end else begin
      relValid <= relAny;
      relTid   <= relPick;
      relSeq   <= headSeq[int'(relPick)*WIDTH*SEQ_W +: SEQ_W];
    end
  end

  // free-entry report
  for (genvar t = 0; t < THREADS; t++) begin : g_free
    logic [CNT_W-1:0] prevCnt, freeQ, cur;
    logic             updQ;

    assign cur = robCount[t*CNT_W +: CNT_W];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prevCnt <= '0;
        freeQ   <= DEPTH_C;
        updQ    <= 1'b0;
      end else begin
        prevCnt <= cur;
        freeQ   <= DEPTH_C - cur;
        updQ    <= (cur != prevCnt);
      end
    end

    assign freeEntries[t*CNT_W +: CNT_W] = freeQ;
    assign freeUpdate[t] = updQ;
  end

endmodule

// File: rtl/retire_ctl.sv
module retire_ctl
  import retire_pkg::*;
#(
  parameter int THREADS   = 2,
  parameter int WIDTH     = 4,
  parameter int SEQ_W     = 16,
  parameter int ROB_DEPTH = 32,
  parameter int TRAP_LAT  = 4,
  localparam int CNT_W    = $clog2(ROB_DEPTH + 1),
  localparam int TID_W    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [THREADS-1:0]             threadEnable,
  input  logic [THREADS*WIDTH-1:0]       headValid,
  input  logic [THREADS*WIDTH-1:0]       headDone,
  input  logic [THREADS*WIDTH-1:0]       headNonSpec,
  input  logic [THREADS*WIDTH*SEQ_W-1:0] headSeq,
  input  logic [THREADS*CNT_W-1:0]       robCount,
  input  logic [THREADS-1:0]             squashReq,
  input  logic [THREADS-1:0]             squashDone,
  input  logic [THREADS-1:0]             trapReq,
  input  logic [THREADS-1:0]             fetchTrapReq,
  input  logic [THREADS-1:0]             storeBusy,
  output logic [WIDTH-1:0]               retireMask,
  output logic [TID_W-1:0]               retireTid,
  output logic                           relValid,
  output logic [TID_W-1:0]               relTid,
  output logic [SEQ_W-1:0]               relSeq,
  output logic [THREADS-1:0]             trapSquash,
  output logic [THREADS*CNT_W-1:0]       freeEntries,
  output logic [THREADS-1:0]             freeUpdate,
  output logic [THREADS*3-1:0]           threadState,
  output logic                           stageActive
);

  thrStrobe_t [THREADS-1:0] strobes;

  retire_fsm #(
    .THREADS (THREADS),
    .TRAP_LAT(TRAP_LAT),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .threadEnable(threadEnable),
    .squashReq   (squashReq),
    .squashDone  (squashDone),
    .trapReq     (trapReq),
    .fetchTrapReq(fetchTrapReq),
    .storeBusy   (storeBusy),
    .robCount    (robCount),
    .strobes     (strobes),
    .trapSquash  (trapSquash),
    .threadState (threadState),
    .stageActive (stageActive)
  );

  retire_path #(
    .THREADS  (THREADS),
    .WIDTH    (WIDTH),
    .SEQ_W    (SEQ_W),
    .ROB_DEPTH(ROB_DEPTH),
    .CNT_W    (CNT_W),
    .TID_W    (TID_W)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .headValid  (headValid),
    .headDone   (headDone),
    .headNonSpec(headNonSpec),
    .headSeq    (headSeq),
    .robCount   (robCount),
    .retireMask (retireMask),
    .retireTid  (retireTid),
    .relValid   (relValid),
    .relTid     (relTid),
    .relSeq     (relSeq),
    .freeEntries(freeEntries),
    .freeUpdate (freeUpdate)
  );

endmodule

// File: rtl/retire_chk.sv
module retire_chk #(
  parameter int THREADS   = 2,
  parameter int WIDTH     = 4,
  parameter int SEQ_W     = 16,
  parameter int ROB_DEPTH = 32,
  parameter int TRAP_LAT  = 4,
  parameter int CNT_W     = 6,
  parameter int TID_W     = 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [THREADS-1:0]             threadEnable,
  input logic [THREADS*WIDTH-1:0]       headValid,
  input logic [THREADS*WIDTH-1:0]       headDone,
  input logic [THREADS*WIDTH-1:0]       headNonSpec,
  input logic [THREADS*WIDTH*SEQ_W-1:0] headSeq,
  input logic [THREADS*CNT_W-1:0]       robCount,
  input logic [THREADS-1:0]             squashReq,
  input logic [THREADS-1:0]             squashDone,
  input logic [THREADS-1:0]             trapReq,
  input logic [THREADS-1:0]             fetchTrapReq,
  input logic [THREADS-1:0]             storeBusy,
  input logic [WIDTH-1:0]               retireMask,
  input logic [TID_W-1:0]               retireTid,
  input logic                           relValid,
  input logic [TID_W-1:0]               relTid,
  input logic [SEQ_W-1:0]               relSeq,
  input logic [THREADS-1:0]             trapSquash,
  input logic [THREADS*CNT_W-1:0]       freeEntries,
  input logic [THREADS-1:0]             freeUpdate,
  input logic [THREADS*3-1:0]           threadState,
  input logic                           stageActive
);

  logic [2:0] selState;
  assign selState = threadState[int'(retireTid)*3 +: 3];

  AST_RETIRE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((WIDTH'(retireMask + 1'b1) & retireMask) == '0)); // R1

  AST_RETIRE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (retireMask != '0) |-> (selState == 3'd0 || selState == 3'd4)); // R5

  for (genvar t = 0; t < THREADS; t++) begin : g_chk
    AST_RELEASE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (relValid && relTid == TID_W'(t)) |->
        $past(headValid[t*WIDTH] && headNonSpec[t*WIDTH] && !headDone[t*WIDTH])); // R3

    AST_TRAP_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      trapSquash[t] |-> (threadState[t*3 +: 3] == 3'd2 &&
                         $past(threadState[t*3 +: 3]) == 3'd3)); // R6

    AST_TRAP_STORES: assert property (@(posedge clk) disable iff (!rst_n)
      trapSquash[t] |-> !$past(storeBusy[t])); // R7

    AST_SQUASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (threadState[t*3 +: 3] == 3'd2 && !squashDone[t]) |=>
        threadState[t*3 +: 3] == 3'd2); // R5
  end

endmodule

bind retire_ctl retire_chk #(
  .THREADS  (THREADS),
  .WIDTH    (WIDTH),
  .SEQ_W    (SEQ_W),
  .ROB_DEPTH(ROB_DEPTH),
  .TRAP_LAT (TRAP_LAT),
  .CNT_W    (CNT_W),
  .TID_W    (TID_W)
) u_chk (.*);

// File: tb/retire_ctl_bench.sv
module retire_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T     = 2;
  localparam int W     = 4;
  localparam int SW    = 16;
  localparam int DEPTH = 32;
  localparam int LAT   = 4;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TW    = 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [T-1:0]     threadEnable, squashReq, squashDone, trapReq, fetchTrapReq, storeBusy;
  logic [T*W-1:0]   headValid, headDone, headNonSpec;
  logic [T*W*SW-1:0] headSeq;
  logic [T*CW-1:0]  robCount;
  logic [W-1:0]     retireMask;
  logic [TW-1:0]    retireTid, relTid;
  logic             relValid, stageActive;
  logic [SW-1:0]    relSeq;
  logic [T-1:0]     trapSquash, freeUpdate;
  logic [T*CW-1:0]  freeEntries;
  logic [T*3-1:0]   threadState;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retire_ctl #(.THREADS(T), .WIDTH(W), .SEQ_W(SW), .ROB_DEPTH(DEPTH), .TRAP_LAT(LAT))
  u_retire_ctl (
    .clk(clk), .rst_n(rst_n), .threadEnable(threadEnable), .headValid(headValid),
    .headDone(headDone), .headNonSpec(headNonSpec), .headSeq(headSeq),
    .robCount(robCount), .squashReq(squashReq), .squashDone(squashDone),
    .trapReq(trapReq), .fetchTrapReq(fetchTrapReq), .storeBusy(storeBusy),
    .retireMask(retireMask), .retireTid(retireTid), .relValid(relValid),
    .relTid(relTid), .relSeq(relSeq), .trapSquash(trapSquash),
    .freeEntries(freeEntries), .freeUpdate(freeUpdate),
    .threadState(threadState), .stageActive(stageActive)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] stOf(input int t);
    return threadState[t*3 +: 3];
  endfunction

  task automatic doReset();
    rst_n = 1'b0;
    threadEnable = '1; squashReq = '0; squashDone = '0; trapReq = '0;
    fetchTrapReq = '0; storeBusy = '0; headValid = '0; headDone = '0;
    headNonSpec = '0; headSeq = '0; robCount = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic testReset();
    doReset();
    chk("R11 state t0", stOf(0), 0);
    chk("R11 state t1", stOf(1), 0);
    chk("R11 stageActive", stageActive, 1);
    chk("R11 relValid", relValid, 0);
    chk("R11 trapSquash", trapSquash, 0);
    chk("R11 freeUpdate", freeUpdate, 0);
    chk("R11 freeEntries t0", freeEntries[0 +: CW], DEPTH);
    chk("R11 retireMask", retireMask, 0);
  endtask

  task automatic testPrefix();
    doReset();
    headValid[3:0] = 4'b1111; headDone[3:0] = 4'b1011; #1;
    chk("R1 stop at slot2", retireMask, 4'b0011);
    chk("R1 tid", retireTid, 0);
    headDone[3:0] = 4'b1111; #1;
    chk("R1 full width", retireMask, 4'b1111);
    headDone[3:0] = 4'b1110; #1;
    chk("R1 head not done", retireMask, 4'b0000);
    headValid[3:0] = 4'b0011; headDone[3:0] = 4'b1111; #1;
    chk("R1 stop at invalid", retireMask, 4'b0011);
  endtask

  task automatic testRoundRobin();
    doReset();
    headValid[0] = 1'b1; headDone[0] = 1'b1;
    headValid[W] = 1'b1; headDone[W] = 1'b1; #1;
    chk("R2 first tid", retireTid, 0);
    tick();
    chk("R2 second tid", retireTid, 1);
    chk("R2 second mask", retireMask, 4'b0001);
    tick();
    chk("R2 wraps tid", retireTid, 0);
    headDone[W] = 1'b0; #1;
    chk("R2 only t0", retireTid, 0);
  endtask

  task automatic testRelease();
    doReset();
    headValid[0] = 1'b1; headNonSpec[0] = 1'b1; headSeq[0 +: SW] = 16'h0055; #1;
    chk("R3 not yet", relValid, 0);
    tick();
    chk("R3 announced", relValid, 1);
    chk("R3 seq", relSeq, 16'h0055);
    chk("R3 tid", relTid, 0);
    tick();
    chk("R3 once only", relValid, 0);
    doReset();
    headValid[1:0] = 2'b11; headNonSpec[1] = 1'b1; headDone[1:0] = 2'b00;
    tick();
    chk("R3 not at head", relValid, 0);
  endtask

  task automatic testReleaseOne();
    doReset();
    headValid[0] = 1'b1; headNonSpec[0] = 1'b1; headSeq[0 +: SW] = 16'h0011;
    headValid[W] = 1'b1; headNonSpec[W] = 1'b1; headSeq[W*SW +: SW] = 16'h0022;
    tick();
    chk("R4 first valid", relValid, 1);
    chk("R4 first tid", relTid, 0);
    chk("R4 first seq", relSeq, 16'h0011);
    tick();
    chk("R4 second valid", relValid, 1);
    chk("R4 second tid", relTid, 1);
    chk("R4 second seq", relSeq, 16'h0022);
    tick();
    chk("R4 done", relValid, 0);
  endtask

  task automatic testSquash();
    doReset();
    headValid[0] = 1'b1; headDone[0] = 1'b1;
    squashReq[0] = 1'b1;
    tick();
    squashReq[0] = 1'b0; #1;
    chk("R5 squashing", stOf(0), 2);
    chk("R5 no retire", retireMask, 0);
    trapReq[0] = 1'b1;
    tick();
    trapReq[0] = 1'b0;
    repeat (2) tick();
    chk("R5 holds", stOf(0), 2);
    squashDone[0] = 1'b1;
    tick();
    squashDone[0] = 1'b0; #1;
    chk("R5 back to run", stOf(0), 0);
    chk("R5 retires again", retireMask, 4'b0001);
  endtask

  task automatic testTrap();
    doReset();
    headValid[0] = 1'b1; headDone[0] = 1'b1;
    trapReq[0] = 1'b1;
    tick();
    trapReq[0] = 1'b0; #1;
    chk("R6 pending", stOf(0), 3);
    chk("R6 no retire", retireMask, 0);
    for (int i = 1; i < LAT; i++) begin
      tick();
      chk("R6 waiting", trapSquash[0], 0);
    end
    tick();
    chk("R6 fire", trapSquash[0], 1);
    chk("R6 squash state", stOf(0), 2);
    tick();
    chk("R6 pulse ends", trapSquash[0], 0);
  endtask

  task automatic testStores();
    doReset();
    storeBusy[0] = 1'b1;
    trapReq[0] = 1'b1;
    tick();
    trapReq[0] = 1'b0;
    repeat (LAT + 3) tick();
    chk("R7 held by stores", stOf(0), 3);
    chk("R7 no pulse", trapSquash[0], 0);
    storeBusy[0] = 1'b0;
    tick();
    chk("R7 fire after stores", trapSquash[0], 1);
  endtask

  task automatic testPriority();
    doReset();
    trapReq[0] = 1'b1; squashReq[0] = 1'b1; fetchTrapReq[0] = 1'b1;
    squashReq[1] = 1'b1; fetchTrapReq[1] = 1'b1;
    tick();
    trapReq = '0; fetchTrapReq = '0;
    squashReq[1] = 1'b0; #1;
    chk("R12 trap wins", stOf(0), 3);
    chk("R12 squash beats fetch trap", stOf(1), 2);
    tick();
    squashReq[0] = 1'b0; #1;
    chk("R12 squash ignored in trap", stOf(0), 3);
  endtask

  task automatic testFetchTrap();
    doReset();
    robCount[0 +: CW] = 6'd3;
    fetchTrapReq[0] = 1'b1;
    tick();
    fetchTrapReq[0] = 1'b0;
    headValid[0] = 1'b1; headDone[0] = 1'b1; #1;
    chk("R8 waiting state", stOf(0), 4);
    chk("R8 still retires", retireMask, 4'b0001);
    tick();
    chk("R8 not empty yet", stOf(0), 4);
    robCount[0 +: CW] = '0; headValid[0] = 1'b0;
    tick();
    chk("R8 to trap pending", stOf(0), 3);
  endtask

  task automatic testFree();
    doReset();
    robCount[0 +: CW] = 6'd5;
    tick();
    chk("R9 update pulse", freeUpdate, 2'b01);
    chk("R9 free t0", freeEntries[0 +: CW], DEPTH - 5);
    tick();
    chk("R9 no repeat", freeUpdate, 2'b00);
    chk("R9 free t1", freeEntries[CW +: CW], DEPTH);
  endtask

  task automatic testIdle();
    doReset();
    threadEnable = '0;
    tick();
    chk("R10 idle t0", stOf(0), 1);
    chk("R10 idle t1", stOf(1), 1);
    chk("R10 inactive", stageActive, 0);
    trapReq[0] = 1'b1; squashReq[1] = 1'b1;
    tick();
    trapReq = '0; squashReq = '0; #1;
    chk("R10 trap ignored", stOf(0), 1);
    chk("R10 squash ignored", stOf(1), 1);
    threadEnable[1] = 1'b1;
    tick();
    chk("R10 resume", stOf(1), 0);
    chk("R10 active", stageActive, 1);
  endtask

  initial begin
    testReset();
    testPrefix();
    testRoundRobin();
    testRelease();
    testReleaseOne();
    testSquash();
    testTrap();
    testStores();
    testPriority();
    testFetchTrap();
    testFree();
    testIdle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule